// File: doc/BRIEF.md
# Triggered Run/Stop Clock-Enable Controller

This block sits between a fast master clock and a waveform synthesis datapath. It runs entirely on the master clock and does not produce divided clocks. Instead it produces single-cycle clock-enable pulses at half rate and at quarter rate. It also produces two half-rate enables for the odd and even memory banks, and each bank enable can be switched off on its own.

A one-bit run state decides whether any enable pulses are produced. After reset the controller is stopped and waits for a trigger. A synchronized trigger clears the stopped state but holds the dividers idle while it stays high. Pulses begin at a fixed phase once the trigger falls. The synthesis logic ends a run by raising a stop request. In gated burst mode, a stop request that arrives while the external gate is active is ignored. The request ends the run only once the gate is inactive.

The divide ratios, the extra latency on the quarter-rate path and the gate polarity are all parameters.

Top module: `trc_runstop`

## Requirements
- R1: A synchronous active-high reset drives stopped_o to 1 and half_en_o, quarter_en_o, odd_en_o and even_en_o to 0 at the clock edge after reset is sampled.
- R2: A master clock edge that samples trig_sync_i = 1 makes stopped_o 0 after that edge.
- R3: After an edge that samples trig_sync_i = 1 or stopped_o = 1, half_en_o, odd_en_o and even_en_o are 0.
- R4: When the controller is running and trig_sync_i has gone low, half_en_o first goes high after the second edge that samples trig_sync_i = 0. After that it is a one-cycle pulse every HALF_DIV cycles while the run lasts.
- R5: Every QTR_DIV-th half-rate pulse of a run also produces a one-cycle quarter_en_o pulse, delayed by QTR_SKEW master cycles. With the defaults, this pulse appears one cycle after the 2nd, 4th, 6th ... half_en_o pulse.
- R6: odd_en_o equals half_en_o AND the value of odd_en_i sampled at the same edge.
- R7: even_en_o equals half_en_o AND the value of even_en_i sampled at the same edge.
- R8: With burst_mode_i = 0, an edge that samples stop_req_i = 1 while running and with trig_sync_i = 0 makes stopped_o 1 after that edge.
- R9: With burst_mode_i = 1 and the gate active (gate_i = 1 for GATE_ACTIVE_HIGH = 1), stop_req_i has no effect and stopped_o stays 0.
- R10: With burst_mode_i = 1 and the gate inactive (gate_i = 0 for GATE_ACTIVE_HIGH = 1), stop_req_i stops the run as in R8.
- R11: When trig_sync_i and stop_req_i are both 1 at the same edge, the trigger wins and stopped_o is 0 after the edge.
- R12: While stopped, a stop request has no effect. stopped_o stays 1 until a trigger is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_sync_i | input | 1 | Trigger, already synchronized to clk |
| stop_req_i | input | 1 | Stop request from the synthesis logic |
| burst_mode_i | input | 1 | 1 selects gated burst mode |
| gate_i | input | 1 | Burst gate, polarity set by GATE_ACTIVE_HIGH |
| odd_en_i | input | 1 | Allows pulses on odd_en_o |
| even_en_i | input | 1 | Allows pulses on even_en_o |
| half_en_o | output | 1 | Half-rate clock-enable pulse |
| quarter_en_o | output | 1 | Quarter-rate clock-enable pulse, delayed by the skew stages |
| odd_en_o | output | 1 | Half-rate enable for the odd bank |
| even_en_o | output | 1 | Half-rate enable for the even bank |
| stopped_o | output | 1 | Registered run state, 1 = stopped |

## Verification
The bench builds the block with HALF_DIV = 2, QTR_DIV = 2, QTR_SKEW = 1 and an active-high gate. With these values the first half-rate pulse, the alternation of the quarter pulse and the one-cycle quarter lag can all be observed within a few cycles of each trigger release. Short runs and long trigger holds therefore reach every divider phase at which a stop or a new trigger can land. The one-stage skew also exercises the delay-line branch of the generate, including a quarter pulse still in flight when a stop arrives.

// File: rtl/trc_pkg.sv
package trc_pkg;

   // Encoding of the run state flag; the stopped value is the reset value.
   typedef enum logic {
      RS_RUN  = 1'b0,
      RS_STOP = 1'b1
   } run_state_e;

   // Bundle of the raw (unregistered) divider ticks.
   typedef struct packed {
      logic half;
      logic quarter;
   } tick_t;

   // Index of each memory bank in the bank-enable vectors.
   localparam int BANK_ODD  = 0;
   localparam int BANK_EVEN = 1;
   localparam int N_BANKS   = 2;

   // Resolves the burst gate to "active" for either polarity.
   function automatic logic gate_active(input logic gate, input bit active_high);
      return active_high ? gate : ~gate;
   endfunction

endpackage

// File: rtl/trc_run_state.sv
module trc_run_state
   import trc_pkg::*;
#(
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       trig_sync_i,
   input  logic       stop_req_i,
   input  logic       burst_mode_i,
   input  logic       gate_i,
   output run_state_e state_o,
   output logic       run_o
);

   run_state_e state_q;
   run_state_e state_d;
   logic       gate_on;
   logic       stop_take;

   // A stop request counts unless a burst gate is holding the run open.
   assign gate_on   = gate_active(gate_i, GATE_ACTIVE_HIGH);
   assign stop_take = stop_req_i & ~(burst_mode_i & gate_on);

   always_comb begin
      state_d = state_q;
      if (trig_sync_i) begin
         state_d = RS_RUN;
      end else if (state_q == RS_RUN && stop_take) begin
         state_d = RS_STOP;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RS_STOP;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;
   // The dividers advance only when running and no trigger is held.
   assign run_o   = (state_q == RS_RUN) & ~trig_sync_i;

endmodule

// File: rtl/trc_divider.sv
module trc_divider #(
   parameter int RATIO = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   input  logic adv_i,
   output logic tick_o
);

   localparam int CW    = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam bit POW2  = (RATIO > 1) && ((RATIO & (RATIO - 1)) == 0);
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   initial begin
      assert (RATIO >= 2)
         else $error("trc_divider: RATIO must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign tick_o  = run_i & adv_i & at_last;

   generate
      if (POW2) begin : g_pow2
         // Power-of-two ratio: the counter wraps on its own.
         always_ff @(posedge clk) begin
            if (rst || !run_i) begin
               cnt_q <= '0;
            end else if (adv_i) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_mod
         // Other ratios: explicit wrap at the last count.
         always_ff @(posedge clk) begin
            if (rst || !run_i) begin
               cnt_q <= '0;
            end else if (adv_i) begin
               cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/trc_delay.sv
module trc_delay #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 16)
         else $error("trc_delay: STAGES must be within 0..16");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_pipe
         logic [STAGES-1:0] pipe_q;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) begin
                  pipe_q[s] <= 1'b0;
               end else if (s == 0) begin
                  pipe_q[s] <= d_i;
               end else begin
                  pipe_q[s] <= pipe_q[(s == 0) ? 0 : s - 1];
               end
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/trc_bank_gate.sv
module trc_bank_gate #(
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          half_tick_i,
   input  logic [NB-1:0] allow_i,
   output logic [NB-1:0] bank_en_o
);

   initial begin
      assert (NB >= 1)
         else $error("trc_bank_gate: NB must be at least 1");
   end

   // Each bank enable is registered, so allow_i is sampled on the same
   // master edge that registers the half-rate tick.
   for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (rst) begin
            bank_en_o[b] <= 1'b0;
         end else begin
            bank_en_o[b] <= half_tick_i & allow_i[b];
         end
      end
   end

endmodule

// File: rtl/trc_runstop.sv
module trc_runstop
   import trc_pkg::*;
#(
   parameter int HALF_DIV         = 2,
   parameter int QTR_DIV          = 2,
   parameter int QTR_SKEW         = 1,
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_sync_i,
   input  logic stop_req_i,
   input  logic burst_mode_i,
   input  logic gate_i,
   input  logic odd_en_i,
   input  logic even_en_i,
   output logic half_en_o,
   output logic quarter_en_o,
   output logic odd_en_o,
   output logic even_en_o,
   output logic stopped_o
);

   initial begin
      assert (HALF_DIV >= 2)
         else $error("trc_runstop: HALF_DIV must be at least 2");
      assert (QTR_DIV >= 2)
         else $error("trc_runstop: QTR_DIV must be at least 2");
      assert (QTR_SKEW >= 0 && QTR_SKEW <= 16)
         else $error("trc_runstop: QTR_SKEW must be within 0..16");
   end

   run_state_e         state;
   logic               run;
   tick_t              tick;
   logic               half_q;
   logic               qtr_base_q;
   logic [N_BANKS-1:0] bank_allow;
   logic [N_BANKS-1:0] bank_en;

   trc_run_state #(
      .GATE_ACTIVE_HIGH (GATE_ACTIVE_HIGH)
   ) u_state (
      .clk          (clk),
      .rst          (rst),
      .trig_sync_i  (trig_sync_i),
      .stop_req_i   (stop_req_i),
      .burst_mode_i (burst_mode_i),
      .gate_i       (gate_i),
      .state_o      (state),
      .run_o        (run)
   );

   // First stage: master clock to half rate.
   trc_divider #(
      .RATIO (HALF_DIV)
   ) u_div_half (
      .clk    (clk),
      .rst    (rst),
      .run_i  (run),
      .adv_i  (1'b1),
      .tick_o (tick.half)
   );

   // Second stage: half rate to quarter rate, advancing on half ticks.
   trc_divider #(
      .RATIO (QTR_DIV)
   ) u_div_qtr (
      .clk    (clk),
      .rst    (rst),
      .run_i  (run),
      .adv_i  (tick.half),
      .tick_o (tick.quarter)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         half_q     <= 1'b0;
         qtr_base_q <= 1'b0;
      end else begin
         half_q     <= tick.half;
         qtr_base_q <= tick.quarter;
      end
   end

   // Fixed skew on the quarter-rate path, in whole master cycles.
   trc_delay #(
      .STAGES (QTR_SKEW)
   ) u_qtr_skew (
      .clk (clk),
      .rst (rst),
      .d_i (qtr_base_q),
      .q_o (quarter_en_o)
   );

   assign bank_allow[BANK_ODD]  = odd_en_i;
   assign bank_allow[BANK_EVEN] = even_en_i;

   trc_bank_gate #(
      .NB (N_BANKS)
   ) u_banks (
      .clk         (clk),
      .rst         (rst),
      .half_tick_i (tick.half),
      .allow_i     (bank_allow),
      .bank_en_o   (bank_en)
   );

   assign half_en_o = half_q;
   assign odd_en_o  = bank_en[BANK_ODD];
   assign even_en_o = bank_en[BANK_EVEN];
   assign stopped_o = (state == RS_STOP);

endmodule

// File: rtl/trc_runstop_chk.sv
module trc_runstop_chk #(
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic trig_sync_i,
   input logic stop_req_i,
   input logic burst_mode_i,
   input logic gate_i,
   input logic odd_en_i,
   input logic even_en_i,
   input logic half_en_o,
   input logic quarter_en_o,
   input logic odd_en_o,
   input logic even_en_o,
   input logic stopped_o
);

   logic gate_on;
   assign gate_on = GATE_ACTIVE_HIGH ? gate_i : ~gate_i;

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (stopped_o && !half_en_o && !odd_en_o && !even_en_o)); // R1

   AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
      trig_sync_i |=> !stopped_o); // R2

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
      (trig_sync_i || stopped_o) |=> (!half_en_o && !odd_en_o && !even_en_o)); // R3

   AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (rst)
      half_en_o |=> !half_en_o); // R4

   AST_QTR_SINGLE: assert property (@(posedge clk) disable iff (rst)
      quarter_en_o |=> !quarter_en_o); // R5

   AST_ODD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      odd_en_i |=> (odd_en_o == half_en_o)); // R6

   AST_ODD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      !odd_en_i |=> !odd_en_o); // R6

   AST_EVEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      even_en_i |=> (even_en_o == half_en_o)); // R7

   AST_EVEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      !even_en_i |=> !even_en_o); // R7

   AST_NORMAL_STOP: assert property (@(posedge clk) disable iff (rst)
      (!stopped_o && !trig_sync_i && stop_req_i && !burst_mode_i) |=> stopped_o); // R8

   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!stopped_o && burst_mode_i && gate_on) |=> !stopped_o); // R9

   AST_BURST_STOP: assert property (@(posedge clk) disable iff (rst)
      (!stopped_o && !trig_sync_i && stop_req_i && burst_mode_i && !gate_on) |=> stopped_o); // R10

   AST_TRIG_WINS: assert property (@(posedge clk) disable iff (rst)
      (trig_sync_i && stop_req_i) |=> !stopped_o); // R11

   AST_STAY_STOPPED: assert property (@(posedge clk) disable iff (rst)
      (stopped_o && !trig_sync_i) |=> stopped_o); // R12

endmodule

bind trc_runstop trc_runstop_chk #(
   .GATE_ACTIVE_HIGH (GATE_ACTIVE_HIGH)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .trig_sync_i  (trig_sync_i),
   .stop_req_i   (stop_req_i),
   .burst_mode_i (burst_mode_i),
   .gate_i       (gate_i),
   .odd_en_i     (odd_en_i),
   .even_en_i    (even_en_i),
   .half_en_o    (half_en_o),
   .quarter_en_o (quarter_en_o),
   .odd_en_o     (odd_en_o),
   .even_en_o    (even_en_o),
   .stopped_o    (stopped_o)
);

// File: tb/tb_trc_runstop.sv
module tb_trc_runstop;

   localparam int HD   = 2;
   localparam int QD   = 2;
   localparam int SKEW = 1;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trig = 1'b0, stop = 1'b0, burst = 1'b0, gate = 1'b0;
   logic odd_i = 1'b1, even_i = 1'b1;
   logic half_o, qtr_o, odd_o, even_o, stopped_o;

   int vectors = 0;
   int misses  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   trc_runstop #(
      .HALF_DIV (HD), .QTR_DIV (QD), .QTR_SKEW (SKEW), .GATE_ACTIVE_HIGH (1'b1)
   ) dut (
      .clk (clk), .rst (rst), .trig_sync_i (trig), .stop_req_i (stop),
      .burst_mode_i (burst), .gate_i (gate), .odd_en_i (odd_i), .even_en_i (even_i),
      .half_en_o (half_o), .quarter_en_o (qtr_o), .odd_en_o (odd_o),
      .even_en_o (even_o), .stopped_o (stopped_o)
   );

   // Reference model, built from the requirements.
   bit m_stop = 1'b1;
   int m_age  = 0;   // run cycles since the dividers left idle
   bit m_half = 1'b0, m_odd = 1'b0, m_even = 1'b0;
   bit m_qp [SKEW+1];

   // R2 R8 R9 R10 R11 R12: next value of the stopped flag.
   function automatic bit next_stop(bit cur, bit t, bit s, bit b, bit g);
      if (t) return 1'b0;
      if (cur) return 1'b1;
      if (s && !(b && g)) return 1'b1;
      return 1'b0;
   endfunction

   // R4: a half pulse after the run cycle with index HD-1, 2*HD-1, ...
   function automatic bit half_due(int age);
      return (age % HD) == HD - 1;
   endfunction

   // R5: every QD-th half pulse carries a quarter pulse.
   function automatic bit qtr_due(int age);
      return (age % (HD * QD)) == HD * QD - 1;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_stop <= 1'b1;
         m_age  <= 0;
         m_half <= 1'b0; m_odd <= 1'b0; m_even <= 1'b0;
         for (int i = 0; i <= SKEW; i++) m_qp[i] <= 1'b0;
      end else begin
         automatic bit run = !m_stop && !trig;
         automatic bit hp  = run && half_due(m_age);
         m_stop <= next_stop(m_stop, trig, stop, burst, gate);
         m_age  <= run ? m_age + 1 : 0;
         m_half <= hp;
         m_odd  <= hp && odd_i;
         m_even <= hp && even_i;
         m_qp[0] <= run && qtr_due(m_age);
         for (int i = 1; i <= SKEW; i++) m_qp[i] <= m_qp[i-1];
      end
   end

   task automatic chk(string req, logic act, bit exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " R4 half_en_o"}, half_o, m_half);
      chk({tag, " R5 quarter_en_o"}, qtr_o, m_qp[SKEW]);
      chk({tag, " R6 odd_en_o"}, odd_o, m_odd);
      chk({tag, " R7 even_en_o"}, even_o, m_even);
      chk({tag, " stopped_o"}, stopped_o, m_stop);
   endtask

   task automatic step(string tag, bit t, bit s, bit b, bit g, bit o, bit e);
      trig = t; stop = s; burst = b; gate = g; odd_i = o; even_i = e;
      @(negedge clk);
      cyc++;
      check_all(tag);
   endtask

   always @(posedge clk) begin
      if (!done && cyc > WATCHDOG) begin
         done = 1'b1;
         misses++;
         $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      chk("R1 stopped after reset", stopped_o, 1'b1);
      chk("R1 half low after reset", half_o, 1'b0);
      rst = 1'b0;

      // R12: stop requests while stopped do nothing.
      repeat (3) step("R12 stop while stopped", 0, 1, 0, 0, 1, 1);
      // R2 R3: trigger held three cycles, no pulses meanwhile.
      repeat (3) step("R2 R3 trigger held", 1, 0, 0, 0, 1, 1);
      chk("R2 stopped cleared", stopped_o, 1'b0);
      // R4 R5: first pulses after release.
      step("R4 release 1", 0, 0, 0, 0, 1, 1);
      chk("R4 no pulse one cycle after release", half_o, 1'b0);
      step("R4 release 2", 0, 0, 0, 0, 1, 1);
      chk("R4 first half pulse", half_o, 1'b1);
      repeat (6) step("R5 run", 0, 0, 0, 0, 1, 0);
      // R6 R7: bank enables off.
      repeat (4) step("R6 R7 banks off", 0, 0, 0, 0, 0, 0);
      repeat (4) step("R6 odd only", 0, 0, 0, 0, 1, 0);
      // R9: burst mode with gate active ignores stops.
      repeat (6) step("R9 burst gate on", 0, 1, 1, 1, 1, 1);
      chk("R9 still running", stopped_o, 1'b0);
      // R10: gate drops, stop takes effect.
      step("R10 burst gate off", 0, 1, 1, 0, 1, 1);
      chk("R10 stopped", stopped_o, 1'b1);
      repeat (3) step("R3 idle", 0, 0, 0, 0, 1, 1);
      // R11: trigger and stop together.
      step("R11 trig and stop", 1, 1, 0, 0, 1, 1);
      chk("R11 trigger wins", stopped_o, 1'b0);
      repeat (5) step("R4 run", 0, 0, 0, 0, 1, 1);
      // R8: normal stop.
      step("R8 normal stop", 0, 1, 0, 0, 1, 1);
      chk("R8 stopped", stopped_o, 1'b1);
      repeat (3) step("R3 after stop", 0, 0, 0, 0, 1, 1);

      // Constrained random mix.
      for (int n = 0; n < 4000; n++) begin
         automatic bit t = ($urandom % 16) == 0;
         automatic bit s = ($urandom % 9) == 0;
         automatic bit b = (n / 200) % 2 == 1;
         automatic bit g = ((n / 7) % 3) != 0;
         automatic bit o = ($urandom % 4) != 0;
         automatic bit e = ($urandom % 3) != 0;
         step("R2 R3 R8 R9 R10 R11 R12 random", t, s, b, g, o, e);
      end

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule